// File: doc/BRIEF.md
# Incremental Decimator with Temperature Mapping

This block is the digital back end of a bandgap-style temperature sensor. A second-order incremental modulator delivers a one-bit stream. The block accepts exactly 512 qualified samples per conversion and sends them through two cascaded accumulators. Both accumulators are cleared when a conversion starts, so each conversion depends only on its own bits. The second accumulator ends holding a triangularly weighted sum of the bits. That sum, divided by the total weight 512·513/2, is the bit-stream density X.

X is then turned into a temperature with a rational curve, T = A·kX/(1+kX) + B. The calibration factor k, the gain A and the offset B are all programmable, which allows per-die trimming. The offset is applied after the curve, so a one-point trim can shift B alone. The normalisation and the division fold into a single quotient, kS/(kS+W). A sequential restoring divider computes that quotient after the last sample. Done pulses once the quotient is ready.

Top module: `temp_decim_top`

## Requirements
- R1: After reset, busy and done are 0 and temp_out is 0.
- R2: A start pulse while idle clears both accumulators, captures the coefficients and raises busy on the next clock edge.
- R3: A conversion takes exactly 512 samples, counted only on cycles with bit_vld high. While bit_vld is low, bit_in is ignored. Busy stays high until all 512 samples have arrived.
- R4: The filtered value is S = Σ b_i·(512−i), where i = 0 is the first sample. An all-zero stream gives S = 0 and an all-one stream gives S = 131328.
- R5: The quotient is q = floor(k·S·2^16 / (k·S + 131328·2^12)). The result is temp_out = floor(A·q / 2^16) + B. Here k is unsigned with 12 fraction bits, A is unsigned with 6 fraction bits, B is two's-complement with 6 fraction bits, and temp_out is two's-complement with 6 fraction bits (1/64 °C per LSB).
- R6: A temp_out value outside −32768..32767 saturates to the nearer limit.
- R7: The coefficients are sampled at start. Changing coef_k, coef_a or coef_b during a conversion has no effect on that conversion's result.
- R8: A start pulse while busy is ignored. The running conversion keeps its sample count and its accumulated state.
- R9: Done is a single-cycle pulse. temp_out takes its new value in the same cycle, and busy is low in that cycle. temp_out holds its value at all other times.
- R10: Conversions are independent. An all-zero conversion that follows an all-one conversion yields exactly B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a conversion (taken only when idle) |
| bit_in | input | 1 | Modulator output bit |
| bit_vld | input | 1 | Qualifies bit_in as a sample |
| coef_k | input | 16 | Calibration factor k, unsigned, 12 fraction bits |
| coef_a | input | 16 | Gain A, unsigned, 6 fraction bits |
| coef_b | input | 16 | Offset B, signed, 6 fraction bits |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle pulse when temp_out is updated |
| temp_out | output | 16 | Temperature, signed, 1/64 °C per LSB |

## Verification
The bench drives first-order density patterns across the sensor range and computes each expected code from the weighted-sum and quotient formulas.

- **Edge streams.** All-zero and all-one streams pin S at 0 and full scale. A design with a wrong triangular weight, or one that misses the last sample, would be off by a visible number of LSBs.
- **Gaps in the valid strobe.** Gaps carry stray ones on bit_in. A design that counted unqualified cycles would finish early, or would absorb those ones.
- **Disturbances mid-conversion.** A restart pulse and a coefficient change are both injected in the middle of a conversion. A design that honoured either one would produce a different code.
- **Saturation and independence.** A maximal gain and offset catch a wrapped result instead of a clamped one. An all-zero conversion right after an all-one conversion exposes leftover filter state.

// File: rtl/temp_decim_pkg.sv
package temp_decim_pkg;

    localparam int DEF_NSAMP = 512;  // samples per conversion
    localparam int DEF_KW    = 16;   // width of k
    localparam int DEF_KFRAC = 12;   // fraction bits of k
    localparam int DEF_AW    = 16;   // width of gain A (6 fraction bits)
    localparam int DEF_TW    = 16;   // width of offset and result (6 fraction bits)
    localparam int DEF_QW    = 16;   // quotient bits

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ACC,
        ST_LOAD,
        ST_DIV
    } conv_state_t;

    function automatic longint tri_weight(input int n);
        return longint'(n) * longint'(n + 1) / 2;
    endfunction

endpackage

// File: rtl/incr_accum.sv
module incr_accum #(
    parameter int NSAMP = 512,
    localparam longint WTOT = temp_decim_pkg::tri_weight(NSAMP),
    localparam int S1W = $clog2(NSAMP + 1),
    localparam int S2W = $clog2(WTOT + 1),
    localparam int CW  = $clog2(NSAMP)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           clr,
    input  logic           en,
    input  logic           bit_in,
    output logic [S2W-1:0] sum2,
    output logic           last
);
    logic [S1W-1:0] acc1;
    logic [S1W-1:0] acc1_nxt;
    logic [CW-1:0]  cnt;

    assign acc1_nxt = acc1 + S1W'(bit_in);
    assign last     = en && (cnt == CW'(NSAMP - 1));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            acc1 <= '0;
            sum2 <= '0;
            cnt  <= '0;
        end else if (en) begin
            acc1 <= acc1_nxt;
            sum2 <= sum2 + S2W'(acc1_nxt);
            cnt  <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/restoring_div.sv
module restoring_div #(
    parameter int DW = 35,
    parameter int QW = 16,
    localparam int CNTW = $clog2(QW + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [DW-1:0] num,   // must be below den
    input  logic [DW-1:0] den,
    output logic [QW-1:0] quo,
    output logic          fin
);
    logic [DW-1:0]   rem;
    logic [DW-1:0]   dvs;
    logic [CNTW-1:0] cnt;
    logic            run;
    logic [DW:0]     trial;
    logic            fits;

    assign trial = {rem, 1'b0};
    assign fits  = trial >= {1'b0, dvs};

    always_ff @(posedge clk) begin
        if (rst) begin
            rem <= '0;
            dvs <= '0;
            quo <= '0;
            cnt <= '0;
            run <= 1'b0;
            fin <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (load) begin
                rem <= num;
                dvs <= den;
                quo <= '0;
                cnt <= CNTW'(QW);
                run <= 1'b1;
            end else if (run) begin
                if (fits) begin
                    rem <= DW'(trial - {1'b0, dvs});
                end else begin
                    rem <= trial[DW-1:0];
                end
                quo <= {quo[QW-2:0], fits};
                cnt <= cnt - 1'b1;
                if (cnt == CNTW'(1)) begin
                    run <= 1'b0;
                    fin <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/temp_scale.sv
module temp_scale #(
    parameter int AW = 16,
    parameter int QW = 16,
    parameter int TW = 16,
    localparam int SW = ((AW > TW) ? AW : TW) + 2
) (
    input  logic [QW-1:0]        q,
    input  logic [AW-1:0]        gain,
    input  logic signed [TW-1:0] offs,
    output logic signed [TW-1:0] temp
);
    localparam longint HI_L = (longint'(1) <<< (TW - 1)) - 1;
    localparam logic signed [SW-1:0] HI = SW'(HI_L);
    localparam logic signed [SW-1:0] LO = SW'(-HI_L - 1);

    logic [AW+QW-1:0]    prod;
    logic signed [SW-1:0] scaled;
    logic signed [SW-1:0] offs_x;
    logic signed [SW-1:0] total;

    assign prod   = (AW+QW)'(gain) * (AW+QW)'(q);
    assign scaled = signed'({{(SW-AW){1'b0}}, prod[AW+QW-1:QW]});
    assign offs_x = SW'(offs);
    assign total  = scaled + offs_x;

    always_comb begin
        if (total > HI)      temp = HI[TW-1:0];
        else if (total < LO) temp = LO[TW-1:0];
        else                 temp = total[TW-1:0];
    end
endmodule

// File: rtl/temp_decim_top.sv
module temp_decim_top
    import temp_decim_pkg::*;
#(
    parameter int NSAMP = DEF_NSAMP,
    parameter int KW    = DEF_KW,
    parameter int KFRAC = DEF_KFRAC,
    parameter int AW    = DEF_AW,
    parameter int TW    = DEF_TW,
    parameter int QW    = DEF_QW
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic                 bit_in,
    input  logic                 bit_vld,
    input  logic [KW-1:0]        coef_k,
    input  logic [AW-1:0]        coef_a,
    input  logic signed [TW-1:0] coef_b,
    output logic                 busy,
    output logic                 done,
    output logic signed [TW-1:0] temp_out
);
    localparam longint WTOT = tri_weight(NSAMP);
    localparam int S2W = $clog2(WTOT + 1);
    localparam int PW  = KW + S2W;
    localparam int DW  = PW + 1;
    localparam logic [DW-1:0] DEN_BIAS = DW'(WTOT <<< KFRAC);

    conv_state_t          state;
    logic [KW-1:0]        k_lat;
    logic [AW-1:0]        a_lat;
    logic signed [TW-1:0] b_lat;
    logic                 clr;
    logic                 acc_en;
    logic                 acc_last;
    logic [S2W-1:0]       sum2;
    logic [PW-1:0]        kprod;
    logic [DW-1:0]        den;
    logic [QW-1:0]        quo;
    logic                 div_fin;
    logic signed [TW-1:0] temp_nxt;

    assign clr    = (state == ST_IDLE) && start;
    assign acc_en = (state == ST_ACC) && bit_vld;
    assign busy   = (state != ST_IDLE);
    assign kprod  = PW'(k_lat) * PW'(sum2);
    assign den    = DW'(kprod) + DEN_BIAS;

    incr_accum #(.NSAMP(NSAMP)) u_acc (
        .clk    (clk),
        .rst    (rst),
        .clr    (clr),
        .en     (acc_en),
        .bit_in (bit_in),
        .sum2   (sum2),
        .last   (acc_last)
    );

    restoring_div #(.DW(DW), .QW(QW)) u_div (
        .clk  (clk),
        .rst  (rst),
        .load (state == ST_LOAD),
        .num  (DW'(kprod)),
        .den  (den),
        .quo  (quo),
        .fin  (div_fin)
    );

    temp_scale #(.AW(AW), .QW(QW), .TW(TW)) u_scale (
        .q    (quo),
        .gain (a_lat),
        .offs (b_lat),
        .temp (temp_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            k_lat    <= '0;
            a_lat    <= '0;
            b_lat    <= '0;
            done     <= 1'b0;
            temp_out <= '0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: if (start) begin
                    k_lat <= coef_k;
                    a_lat <= coef_a;
                    b_lat <= coef_b;
                    state <= ST_ACC;
                end
                ST_ACC:  if (acc_last) state <= ST_LOAD;
                ST_LOAD: state <= ST_DIV;
                ST_DIV:  if (div_fin) begin
                    temp_out <= temp_nxt;
                    done     <= 1'b1;
                    state    <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/temp_decim_chk.sv
module temp_decim_chk #(
    parameter int TW = 16
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 start,
    input logic                 busy,
    input logic                 done,
    input logic signed [TW-1:0] temp_out
);
    // R9: done lasts exactly one cycle
    a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9: the block is idle when done is reported
    a_r9_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R9: the result changes only together with done
    a_r9_result_hold: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(temp_out));

    // R2: busy rises only as a consequence of a start pulse
    a_r2_busy_from_start: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));

    // R9: busy falls only in the cycle that reports done
    a_r9_busy_ends_done: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);
endmodule

bind temp_decim_top temp_decim_chk #(.TW(TW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .temp_out (temp_out)
);

// File: tb/tb_temp_decim_top.sv
module tb_temp_decim_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic bit_in = 1'b0;
    logic bit_vld = 1'b0;
    logic [15:0] coef_k = '0;
    logic [15:0] coef_a = '0;
    logic signed [15:0] coef_b = '0;
    logic busy;
    logic done;
    logic signed [15:0] temp_out;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    localparam int NV = 9;
    localparam int DEF_K = 20693;   // 5.052 * 4096
    localparam int DEF_A = 40621;   // 634.7 * 64
    localparam int DEF_B = -18528;  // -289.5 * 64
    localparam int V_DENS [NV] = '{154, 60, 246, 512, 0, 300, 100, 512, 384};
    localparam int V_K    [NV] = '{DEF_K, DEF_K, DEF_K, DEF_K, DEF_K, 4096, 30000, 65535, 1000};
    localparam int V_A    [NV] = '{DEF_A, DEF_A, DEF_A, DEF_A, DEF_A, 6400, 40000, 65535, 12345};
    localparam int V_B    [NV] = '{DEF_B, DEF_B, DEF_B, DEF_B, DEF_B, 0, -100, 32767, -32768};

    temp_decim_top dut (
        .clk(clk), .rst(rst), .start(start), .bit_in(bit_in), .bit_vld(bit_vld),
        .coef_k(coef_k), .coef_a(coef_a), .coef_b(coef_b),
        .busy(busy), .done(done), .temp_out(temp_out)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: run hung, actual=%0d expected=<150000 cycles", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input string req, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint expect_temp(input longint s, input longint k,
                                           input longint a, input longint b);
        longint p, d, q, t;
        p = k * s;
        d = p + 131328 * 4096;
        q = (p <<< 16) / d;
        t = ((a * q) >>> 16) + b;
        if (t > 32767) t = 32767;
        if (t < -32768) t = -32768;
        return t;
    endfunction

    // mode: 0 plain, 1 restart poke, 2 coefficient change, 3 pause before last sample
    task automatic convert(input int dens, input int kk, input int aa, input int bb,
                           input bit gaps, input int mode, input string req);
        int e = 0;
        longint s = 0;
        bit b;
        bit seen = 0;
        logic signed [15:0] held;
        @(negedge clk);
        coef_k = 16'(kk); coef_a = 16'(aa); coef_b = 16'(bb);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R2 busy after start", longint'(busy), 1);
        for (int i = 0; i < 512; i++) begin
            if (gaps && (i % 5 == 2)) begin
                bit_vld = 1'b0; bit_in = 1'b1;
                @(negedge clk);
            end
            if (mode == 3 && i == 511) begin
                bit_vld = 1'b0; bit_in = 1'b1;
                repeat (5) @(negedge clk);
                check("R3 busy held before last sample", longint'(busy), 1);
            end
            e += dens;
            if (e >= 512) begin b = 1'b1; e -= 512; end else b = 1'b0;
            if (b) s += 512 - i;
            bit_vld = 1'b1; bit_in = b;
            start = (mode == 1 && i == 200);
            if (mode == 2 && i == 200) begin
                coef_k = 16'h1234; coef_a = 16'h0042; coef_b = 16'sh0777;
            end
            @(negedge clk);
            start = 1'b0;
        end
        bit_vld = 1'b0; bit_in = 1'b0;
        for (int w = 0; w < 100 && !seen; w++) begin
            if (done) seen = 1'b1; else @(negedge clk);
        end
        check({req, " done seen"}, longint'(seen), 1);
        check({req, " temperature"}, longint'(temp_out), expect_temp(s, kk, aa, bb));
        check("R9 busy low at done", longint'(busy), 0);
        held = temp_out;
        @(negedge clk);
        check("R9 done single cycle", longint'(done), 0);
        repeat (3) @(negedge clk);
        check("R9 temp_out held", longint'(temp_out), longint'(held));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 busy at reset", longint'(busy), 0);
        check("R1 done at reset", longint'(done), 0);
        check("R1 temp_out at reset", longint'(temp_out), 0);
        rst = 1'b0;
        @(negedge clk);
        // R4 and R5 main table; the fifth row (all zeros right after all ones) also covers R10;
        // row 7 drives R6 saturation
        for (int v = 0; v < NV; v++) begin
            convert(V_DENS[v], V_K[v], V_A[v], V_B[v], v[0], 0,
                    (v == 7) ? "R6 saturation" : (v == 4) ? "R10 zero after ones" : "R5 mapping");
        end
        // R3 idle-strobe gaps with stray ones plus a pause before the final sample
        convert(200, DEF_K, DEF_A, DEF_B, 1'b1, 3, "R3 sample count");
        // R8 start during a conversion is ignored
        convert(170, DEF_K, DEF_A, DEF_B, 1'b0, 1, "R8 restart ignored");
        // R7 coefficients changed mid conversion have no effect
        convert(220, DEF_K, DEF_A, DEF_B, 1'b0, 2, "R7 coef capture");
        // R4 full scale with unit gain: q = floor(k S 2^16/(k S + W 4096)), k=4096 -> 1/2
        convert(512, 4096, 64, 0, 1'b0, 0, "R4 full scale");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule